// File: doc/BRIEF.md
# Atomic register-memory exchange unit

This unit carries out the exchange instruction of a 64-bit core whose prefixes have already been scanned. It receives the opcode byte, the ModRM byte, the REX bits, the operand-size override flag, the LOCK flag, the current privilege level, an alignment-check enable and a ready-made effective address. It owns a 16-entry, 64-bit general register file. The unit swaps two registers in one cycle, or swaps a register with memory through a request/acknowledge port.

During a memory swap the unit holds a bus-lock output for the whole read-then-write sequence, whether or not the LOCK prefix is present. A LOCK prefix on a register-only form is rejected with an invalid-opcode fault. An unaligned memory operand at privilege level 3, with alignment checking enabled, is rejected with an alignment fault before any memory access. A plain load port and a registered observe port give the surrounding core full-width access to the register file between instructions.

Top module: `swap_exec_unit`

## Requirements
- R1: Opcode 0x87 swaps the ModRM reg register (code {rex_r, modrm[5:3]}) with the ModRM r/m register (code {rex_b, modrm[2:0]}) when modrm[7:6] is 3. The width is 64 bits when rex_w is 1. Otherwise it is 16 bits when opsize_ovr is 1, and 32 bits when it is not, so rex_w takes priority. `done` pulses on the cycle after `start`.
- R2: A 32-bit register write clears bits 63:32 of the register. An 8-bit or 16-bit write leaves every bit above the written field unchanged.
- R3: Opcode 0x86 swaps bytes. Without any REX prefix (rex_present 0), byte codes 4 to 7 select bits 15:8 of registers 0 to 3. With rex_present 1 they select bits 7:0 of registers 4 to 7. When both operands lie in the same register, both byte fields are updated.
- R4: Opcodes 0x90 to 0x97 swap register 0 with the register coded {rex_b, opcode[2:0]}, with the width chosen as in R1. Opcode 0x90 with rex_b 0 changes nothing except the 32-bit zero-extension of register 0, and it completes on the cycle after `start`.
- R5: When modrm[7:6] is not 3 for opcode 0x86 or 0x87, the unit issues a read and then a write of the old register value at `mem_addr`. The register receives the data that was read, and `done` pulses with the write acknowledge. `mem_size` is log2 of the byte count (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8). A request stays asserted, with a stable address and direction, until it is acknowledged.
- R6: `mem_lock` rises with the read request, stays high until the write is acknowledged, and falls on the same edge that raises `done`, whether or not `lock_pfx` is set. It is low for register-only forms.
- R7: A LOCK prefix on a register-only form, or any opcode other than 0x86, 0x87 and 0x90 to 0x97, raises `fault_ud` together with `done`. It changes no register, changes no memory and issues no request.
- R8: For a memory form with `ac_en` 1, `cpl` 3, and an address that is not a multiple of the operand size, the unit raises `fault_ac` with `done`. It issues no request and changes no state. If any one of these conditions is absent, the swap proceeds.
- R9: After reset, `done`, both faults, `busy`, `mem_req` and `mem_lock` are 0. `ld_en` writes the full 64-bit `ld_data` into register `ld_idx`. `obs_data` shows register `obs_idx` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (only while idle) |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModRM byte |
| rex_present | input | 1 | Any REX prefix seen |
| rex_w | input | 1 | REX.W |
| rex_r | input | 1 | REX.R |
| rex_b | input | 1 | REX.B |
| opsize_ovr | input | 1 | Operand-size override prefix seen |
| lock_pfx | input | 1 | LOCK prefix seen |
| cpl | input | 2 | Current privilege level |
| ac_en | input | 1 | Alignment checking enabled |
| eff_addr | input | ADDR_W | Effective address of the memory operand |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Register to load |
| ld_data | input | 64 | Load value |
| obs_idx | input | 4 | Register to observe |
| obs_data | output | 64 | Observed register, one cycle later |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| fault_ud | output | 1 | Invalid-opcode fault, valid with done |
| fault_ac | output | 1 | Alignment fault, valid with done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Bus lock |
| mem_addr | output | ADDR_W | Request address |
| mem_size | output | 2 | log2 of byte count |
| mem_wdata | output | 64 | Write data, low-aligned |
| mem_rdata | input | 64 | Read data, low-aligned, valid with ack |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |

## Verification
The assertions assume that `start` arrives only while the unit is idle, and that `ld_en` never coincides with a swap write. They also assume that `mem_ack` is a single-cycle pulse given only while `mem_req` is high. The stimulus keeps to these assumptions. It raises `start` only after the previous `done`, and it loads registers only between instructions. Its memory model answers each request exactly once, after a chosen delay, and drops the acknowledge on the following cycle.

// File: rtl/swx_pkg.sv
package swx_pkg;
  localparam int XLEN   = 64;
  localparam int NREG   = 16;
  localparam int RIDX_W = $clog2(NREG);

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_W = 2'd1, SZ_D = 2'd2, SZ_Q = 2'd3} opsz_e;

  typedef struct packed {
    logic [RIDX_W-1:0] idx;
    logic              hi;
  } rsel_t;

  typedef struct packed {
    logic  legal;
    logic  is_mem;
    opsz_e sz;
    rsel_t ra;
    rsel_t rb;
  } dec_t;

  function automatic logic [XLEN-1:0] slice_get(logic [XLEN-1:0] v, opsz_e sz, logic hi);
    logic [XLEN-1:0] r;
    case (sz)
      SZ_B:    r = hi ? {{(XLEN-8){1'b0}}, v[15:8]} : {{(XLEN-8){1'b0}}, v[7:0]};
      SZ_W:    r = {{(XLEN-16){1'b0}}, v[15:0]};
      SZ_D:    r = {{(XLEN-32){1'b0}}, v[31:0]};
      default: r = v;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] slice_put(logic [XLEN-1:0] old, opsz_e sz, logic hi,
                                                logic [XLEN-1:0] nv);
    logic [XLEN-1:0] r;
    case (sz)
      SZ_B:    r = hi ? {old[XLEN-1:16], nv[7:0], old[7:0]} : {old[XLEN-1:8], nv[7:0]};
      SZ_W:    r = {old[XLEN-1:16], nv[15:0]};
      SZ_D:    r = {{(XLEN-32){1'b0}}, nv[31:0]};
      default: r = nv;
    endcase
    return r;
  endfunction

  function automatic rsel_t map_reg(logic [RIDX_W-1:0] code, logic byte_op, logic rex_any);
    rsel_t s;
    if (byte_op && !rex_any && code[2]) begin
      s.idx = {{(RIDX_W-2){1'b0}}, code[1:0]};
      s.hi  = 1'b1;
    end else begin
      s.idx = code;
      s.hi  = 1'b0;
    end
    return s;
  endfunction
endpackage

// File: rtl/swx_decode.sv
module swx_decode
  import swx_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  input  logic       rex_present,
  input  logic       rex_w,
  input  logic       rex_r,
  input  logic       rex_b,
  input  logic       opsize_ovr,
  output dec_t       dec
);
  logic is_byte, is_modrm_form, is_acc_form;

  always_comb begin
    is_byte       = (opcode == 8'h86);
    is_modrm_form = (opcode == 8'h86) || (opcode == 8'h87);
    is_acc_form   = (opcode[7:3] == 5'b10010);

    dec.legal  = is_modrm_form || is_acc_form;
    dec.is_mem = is_modrm_form && (modrm[7:6] != 2'b11);

    if (is_byte)         dec.sz = SZ_B;
    else if (rex_w)      dec.sz = SZ_Q;
    else if (opsize_ovr) dec.sz = SZ_W;
    else                 dec.sz = SZ_D;

    if (is_modrm_form) begin
      dec.ra = map_reg({rex_r, modrm[5:3]}, is_byte, rex_present);
      dec.rb = map_reg({rex_b, modrm[2:0]}, is_byte, rex_present);
    end else begin
      dec.ra = map_reg('0, 1'b0, rex_present);
      dec.rb = map_reg({rex_b, opcode[2:0]}, 1'b0, rex_present);
    end
  end
endmodule

// File: rtl/swx_regfile.sv
module swx_regfile
  import swx_pkg::*;
(
  input  logic              clk,
  input  logic              ld_en,
  input  logic [RIDX_W-1:0] ld_idx,
  input  logic [XLEN-1:0]   ld_data,
  input  logic              wa_en,
  input  rsel_t             wa_sel,
  input  logic [XLEN-1:0]   wa_val,
  input  logic              wb_en,
  input  rsel_t             wb_sel,
  input  logic [XLEN-1:0]   wb_val,
  input  opsz_e             w_sz,
  input  logic [RIDX_W-1:0] rd_a_idx,
  output logic [XLEN-1:0]   rd_a_data,
  input  logic [RIDX_W-1:0] rd_b_idx,
  output logic [XLEN-1:0]   rd_b_data,
  input  logic [RIDX_W-1:0] obs_idx,
  output logic [XLEN-1:0]   obs_data
);
  logic [XLEN-1:0] rf  [NREG];
  logic [XLEN-1:0] nxt [NREG];
  logic [NREG-1:0] hit;

  assign rd_a_data = rf[rd_a_idx];
  assign rd_b_data = rf[rd_b_idx];

  // Both swap writes merge into one next value per entry, so two byte
  // fields of the same register are updated together.
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      nxt[i] = rf[i];
      hit[i] = 1'b0;
      if (wa_en && wa_sel.idx == RIDX_W'(i)) begin
        nxt[i] = slice_put(nxt[i], w_sz, wa_sel.hi, wa_val);
        hit[i] = 1'b1;
      end
      if (wb_en && wb_sel.idx == RIDX_W'(i)) begin
        nxt[i] = slice_put(nxt[i], w_sz, wb_sel.hi, wb_val);
        hit[i] = 1'b1;
      end
      if (ld_en && ld_idx == RIDX_W'(i)) begin
        nxt[i] = ld_data;
        hit[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (hit[i]) rf[i] <= nxt[i];
    end
    obs_data <= rf[obs_idx];
  end

  // R9: the load port is used only between instructions
  a_r9_load_not_during_swap: assert property (@(posedge clk) ld_en |-> !(wa_en || wb_en));
endmodule

// File: rtl/swx_seq.sv
module swx_seq
  import swx_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  dec_t              dec,
  input  logic              lock_pfx,
  input  logic [1:0]        cpl,
  input  logic              ac_en,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [XLEN-1:0]   a_val,
  input  logic [XLEN-1:0]   b_val,
  output logic              busy,
  output logic              done,
  output logic              fault_ud,
  output logic              fault_ac,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic [XLEN-1:0]   mem_rdata,
  input  logic              mem_ack,
  output logic              wa_en,
  output rsel_t             wa_sel,
  output logic [XLEN-1:0]   wa_val,
  output logic              wb_en,
  output rsel_t             wb_sel,
  output logic [XLEN-1:0]   wb_val,
  output opsz_e             w_sz
);
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

  st_e             st;
  rsel_t           ctx_sel;
  opsz_e           ctx_sz;
  logic [XLEN-1:0] held;
  logic            accept, ud_hit, misaligned, go_reg;
  logic [2:0]      amask;

  always_comb begin
    case (dec.sz)
      SZ_B:    amask = 3'd0;
      SZ_W:    amask = 3'd1;
      SZ_D:    amask = 3'd3;
      default: amask = 3'd7;
    endcase
    accept     = start && (st == ST_IDLE);
    ud_hit     = !dec.legal || (lock_pfx && !dec.is_mem);
    misaligned = ac_en && (cpl == 2'd3) && dec.is_mem && (|(eff_addr[2:0] & amask));
    go_reg     = accept && !ud_hit && !dec.is_mem;
  end

  always_comb begin
    wa_en  = go_reg || (st == ST_WR && mem_ack);
    wa_sel = (st == ST_IDLE) ? dec.ra : ctx_sel;
    wa_val = (st == ST_IDLE) ? b_val : held;
    w_sz   = (st == ST_IDLE) ? dec.sz : ctx_sz;
    wb_en  = go_reg;
    wb_sel = dec.rb;
    wb_val = a_val;
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      done      <= 1'b0;
      fault_ud  <= 1'b0;
      fault_ac  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_lock  <= 1'b0;
      mem_addr  <= '0;
      mem_size  <= 2'd0;
      mem_wdata <= '0;
      ctx_sel   <= '0;
      ctx_sz    <= SZ_B;
      held      <= '0;
    end else begin
      done     <= 1'b0;
      fault_ud <= 1'b0;
      fault_ac <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            if (ud_hit) begin
              done     <= 1'b1;
              fault_ud <= 1'b1;
            end else if (misaligned) begin
              done     <= 1'b1;
              fault_ac <= 1'b1;
            end else if (!dec.is_mem) begin
              done <= 1'b1;
            end else begin
              st        <= ST_RD;
              mem_req   <= 1'b1;
              mem_we    <= 1'b0;
              mem_lock  <= 1'b1;
              mem_addr  <= eff_addr;
              mem_size  <= dec.sz;
              mem_wdata <= a_val;
              ctx_sel   <= dec.ra;
              ctx_sz    <= dec.sz;
            end
          end
        end
        ST_RD: begin
          if (mem_ack) begin
            st     <= ST_WR;
            mem_we <= 1'b1;
            held   <= slice_get(mem_rdata, ctx_sz, 1'b0);
          end
        end
        ST_WR: begin
          if (mem_ack) begin
            st       <= ST_IDLE;
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            mem_lock <= 1'b0;
            done     <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R5: input assumptions and request hold
  a_r5_start_only_idle: assert property (@(posedge clk) disable iff (rst) start |-> !busy);
  a_r5_ack_only_on_req: assert property (@(posedge clk) disable iff (rst) mem_ack |-> mem_req);
  a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($past(mem_ack) && mem_req));
  // R6: lock covers the whole sequence and drops with done
  a_r6_lock_covers_req: assert property (@(posedge clk) disable iff (rst) mem_req |-> mem_lock);
  a_r6_unlock_with_done: assert property (@(posedge clk) disable iff (rst) $fell(mem_lock) |-> done);
  // R7: invalid-opcode fault stays off the bus
  a_r7_ud_quiet: assert property (@(posedge clk) disable iff (rst) fault_ud |-> (!mem_lock && !busy));
  // R8: alignment fault issues no request
  a_r8_ac_quiet: assert property (@(posedge clk) disable iff (rst) fault_ac |-> !mem_req);
  a_r8_one_fault: assert property (@(posedge clk) disable iff (rst)
    (fault_ud || fault_ac) |-> (done && $onehot0({fault_ud, fault_ac})));
endmodule

// File: rtl/swap_exec_unit.sv
module swap_exec_unit
  import swx_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [7:0]        modrm,
  input  logic              rex_present,
  input  logic              rex_w,
  input  logic              rex_r,
  input  logic              rex_b,
  input  logic              opsize_ovr,
  input  logic              lock_pfx,
  input  logic [1:0]        cpl,
  input  logic              ac_en,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              ld_en,
  input  logic [3:0]        ld_idx,
  input  logic [63:0]       ld_data,
  input  logic [3:0]        obs_idx,
  output logic [63:0]       obs_data,
  output logic              busy,
  output logic              done,
  output logic              fault_ud,
  output logic              fault_ac,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_lock,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ack
);
  dec_t            dec;
  logic [XLEN-1:0] rd_a, rd_b, a_val, b_val, wa_val, wb_val;
  logic            wa_en, wb_en;
  rsel_t           wa_sel, wb_sel;
  opsz_e           w_sz;

  swx_decode u_dec (
    .opcode(opcode), .modrm(modrm), .rex_present(rex_present), .rex_w(rex_w),
    .rex_r(rex_r), .rex_b(rex_b), .opsize_ovr(opsize_ovr), .dec(dec)
  );

  assign a_val = slice_get(rd_a, dec.sz, dec.ra.hi);
  assign b_val = slice_get(rd_b, dec.sz, dec.rb.hi);

  swx_regfile u_rf (
    .clk(clk), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .wa_en(wa_en), .wa_sel(wa_sel), .wa_val(wa_val),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val), .w_sz(w_sz),
    .rd_a_idx(dec.ra.idx), .rd_a_data(rd_a),
    .rd_b_idx(dec.rb.idx), .rd_b_data(rd_b),
    .obs_idx(obs_idx), .obs_data(obs_data)
  );

  swx_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .dec(dec), .lock_pfx(lock_pfx),
    .cpl(cpl), .ac_en(ac_en), .eff_addr(eff_addr), .a_val(a_val), .b_val(b_val),
    .busy(busy), .done(done), .fault_ud(fault_ud), .fault_ac(fault_ac),
    .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .wa_en(wa_en), .wa_sel(wa_sel), .wa_val(wa_val),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val), .w_sz(w_sz)
  );
endmodule

// File: tb/sim_swap_exec_unit.sv
`timescale 1ns/1ps
module sim_swap_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h0, modrm = 8'h0;
  logic        rex_present = 0, rex_w = 0, rex_r = 0, rex_b = 0, opsize_ovr = 0, lock_pfx = 0;
  logic [1:0]  cpl = 2'd0;
  logic        ac_en = 0;
  logic [63:0] eff_addr = '0;
  logic        ld_en = 0;
  logic [3:0]  ld_idx = '0, obs_idx = '0;
  logic [63:0] ld_data = '0, obs_data;
  logic        busy, done, fault_ud, fault_ac, mem_req, mem_we, mem_lock;
  logic [63:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic [63:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #10 clk = ~clk;

  swap_exec_unit u0 (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .modrm(modrm),
    .rex_present(rex_present), .rex_w(rex_w), .rex_r(rex_r), .rex_b(rex_b),
    .opsize_ovr(opsize_ovr), .lock_pfx(lock_pfx), .cpl(cpl), .ac_en(ac_en),
    .eff_addr(eff_addr), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .obs_idx(obs_idx), .obs_data(obs_data), .busy(busy), .done(done),
    .fault_ud(fault_ud), .fault_ac(fault_ac), .mem_req(mem_req), .mem_we(mem_we),
    .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int n_cmp = 0, n_bad = 0;
  int mem_lat = 0, wcnt = 0;
  logic [7:0]  dev_mem [256];
  logic [7:0]  exp_mem [256];
  logic [63:0] m_rf [16];

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory device: one acknowledge per request after mem_lat idle cycles
  always @(negedge clk) begin
    if (rst) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (wcnt < mem_lat) wcnt++;
      else begin
        wcnt = 0;
        if (mem_we) begin
          for (int k = 0; k < (1 << mem_size); k++)
            dev_mem[(int'(mem_addr[7:0]) + k) & 255] = mem_wdata[8*k +: 8];
        end else begin
          mem_rdata = '0;
          for (int k = 0; k < (1 << mem_size); k++)
            mem_rdata[8*k +: 8] = dev_mem[(int'(mem_addr[7:0]) + k) & 255];
        end
        mem_ack = 1'b1;
      end
    end
  end

  // ---- reference model ----
  function automatic logic [63:0] mget(int rg, int off, int n);
    logic [63:0] v = '0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = m_rf[rg][8*(off+k) +: 8];
    return v;
  endfunction

  task automatic mput(int rg, int off, int n, logic [63:0] v);
    for (int k = 0; k < n; k++) m_rf[rg][8*(off+k) +: 8] = v[8*k +: 8];
    if (n == 4) m_rf[rg][63:32] = '0;
  endtask

  task automatic locate(int code, int n, bit rp, output int rg, output int off);
    if (n == 1 && !rp && code >= 4 && code < 8) begin rg = code - 4; off = 1; end
    else begin rg = code; off = 0; end
  endtask

  task automatic model_op(logic [7:0] op, logic [7:0] mr, bit rp, bit w, bit r, bit b, bit ovr,
                          bit lk, logic [1:0] cp, bit ac, int addr,
                          output bit eu, output bit ea, output bit em);
    bit legal, ismem;
    int n, ca, cb, ga, oa, gb, ob;
    logic [63:0] va, vb, vm;
    legal = (op == 8'h86) || (op == 8'h87) || (op >= 8'h90 && op <= 8'h97);
    n = (op == 8'h86) ? 1 : (w ? 8 : (ovr ? 2 : 4));
    if (op == 8'h86 || op == 8'h87) begin
      ca = r * 8 + int'(mr[5:3]);
      cb = b * 8 + int'(mr[2:0]);
      ismem = (mr[7:6] != 2'b11);
    end else begin
      ca = 0;
      cb = b * 8 + int'(op[2:0]);
      ismem = 0;
    end
    eu = !legal || (lk && !ismem);
    ea = !eu && ismem && ac && cp == 2'd3 && (addr % n) != 0;
    em = !eu && !ea && ismem;
    locate(ca, n, rp, ga, oa);
    locate(cb, n, rp, gb, ob);
    if (!eu && !ea) begin
      va = mget(ga, oa, n);
      if (!ismem) begin
        vb = mget(gb, ob, n);
        mput(ga, oa, n, vb);
        mput(gb, ob, n, va);
      end else begin
        vm = '0;
        for (int k = 0; k < n; k++) begin
          vm[8*k +: 8] = exp_mem[addr + k];
          exp_mem[addr + k] = va[8*k +: 8];
        end
        mput(ga, oa, n, vm);
      end
    end
  endtask

  // ---- driver tasks ----
  task automatic load_all(logic [63:0] seed);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ld_en = 1; ld_idx = 4'(i);
      ld_data = seed + 64'(i) * 64'h1111_1111_1111_1111;
      m_rf[i] = ld_data;
    end
    @(negedge clk);
    ld_en = 0;
  endtask

  task automatic verify_regs(string req);
    for (int i = 0; i < 16; i++) begin
      obs_idx = 4'(i);
      @(negedge clk);
      chk(obs_data === m_rf[i], req, obs_data, m_rf[i]);
    end
  endtask

  task automatic verify_mem(string req);
    int bad = 0;
    for (int a = 0; a < 256; a++) if (dev_mem[a] !== exp_mem[a]) bad++;
    chk(bad == 0, req, 64'(bad), 64'd0);
  endtask

  task automatic run_op(string req, logic [7:0] op, logic [7:0] mr, bit rp, bit w, bit r, bit b,
                        bit ovr, bit lk, logic [1:0] cp, bit ac, int addr, int lat);
    bit eu, ea, em, exp_lock;
    int cyc;
    model_op(op, mr, rp, w, r, b, ovr, lk, cp, ac, addr, eu, ea, em);
    mem_lat = lat;
    @(negedge clk);
    opcode = op; modrm = mr; rex_present = rp; rex_w = w; rex_r = r; rex_b = b;
    opsize_ovr = ovr; lock_pfx = lk; cpl = cp; ac_en = ac; eff_addr = 64'(addr);
    start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    forever begin
      exp_lock = em && !done;
      chk(mem_lock === exp_lock, "R6", 64'(mem_lock), 64'(exp_lock));
      if (!em) chk(mem_req === 1'b0, "R7", 64'(mem_req), 64'd0);
      if (done) break;
      if (cyc > 60) begin
        chk(0, "R5", 64'(cyc), 64'd0);
        break;
      end
      @(negedge clk);
      cyc++;
    end
    chk(fault_ud === eu, "R7", 64'(fault_ud), 64'(eu));
    chk(fault_ac === ea, "R8", 64'(fault_ac), 64'(ea));
    if (!em) chk(cyc == 1, "R1", 64'(cyc), 64'd1);
    verify_regs(req);
    verify_mem(req);
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) begin
      dev_mem[a] = 8'(a * 7 + 3);
      exp_mem[a] = 8'(a * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9: reset state
    chk({done, fault_ud, fault_ac, busy, mem_req, mem_lock} === 6'b0, "R9",
        64'({done, fault_ud, fault_ac, busy, mem_req, mem_lock}), 64'd0);
    load_all(64'h8070_6050_4030_2010);
    verify_regs("R9");

    // R1: register pairs at each width, REX.W over the override
    run_op("R1", 8'h87, 8'hCA, 1, 1, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    run_op("R2", 8'h87, 8'hD3, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    run_op("R2", 8'h87, 8'hE5, 0, 0, 0, 0, 1, 0, 2'd0, 0, 0, 0);
    run_op("R1", 8'h87, 8'hC8, 1, 1, 1, 0, 1, 0, 2'd0, 0, 0, 0);
    // R3: byte registers
    load_all(64'hF1E2_D3C4_B5A6_9788);
    run_op("R3", 8'h86, 8'hE3, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    run_op("R3", 8'h86, 8'hE3, 1, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    run_op("R3", 8'h86, 8'hE0, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    run_op("R3", 8'h86, 8'hFE, 1, 0, 1, 1, 0, 0, 2'd0, 0, 0, 0);
    // R4: accumulator forms
    run_op("R4", 8'h93, 8'h00, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    run_op("R4", 8'h90, 8'h00, 1, 1, 0, 1, 0, 0, 2'd0, 0, 0, 0);
    run_op("R4", 8'h97, 8'h00, 0, 0, 0, 0, 1, 0, 2'd0, 0, 0, 0);
    load_all(64'h0123_4567_89AB_CDEF);
    run_op("R4", 8'h90, 8'h00, 1, 1, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    run_op("R4", 8'h90, 8'h00, 0, 0, 0, 0, 0, 0, 2'd0, 0, 0, 0);
    // R7: locked register form and undefined opcode
    load_all(64'h5A5A_0000_A5A5_1234);
    run_op("R7", 8'h87, 8'hCA, 1, 1, 0, 0, 0, 1, 2'd0, 0, 0, 0);
    run_op("R7", 8'h90, 8'h00, 0, 0, 0, 0, 0, 1, 2'd0, 0, 0, 0);
    run_op("R7", 8'h88, 8'h08, 0, 0, 0, 0, 0, 0, 2'd0, 0, 16, 0);
    // R5 / R6: memory forms with various latencies
    run_op("R5", 8'h87, 8'h08, 1, 1, 0, 0, 0, 0, 2'd0, 0, 16, 0);
    run_op("R5", 8'h87, 8'h50, 0, 0, 0, 0, 0, 0, 2'd3, 1, 40, 3);
    run_op("R3", 8'h86, 8'h20, 0, 0, 0, 0, 0, 0, 2'd3, 1, 7, 1);
    run_op("R6", 8'h87, 8'h18, 0, 0, 0, 0, 1, 1, 2'd0, 0, 2, 2);
    run_op("R6", 8'h86, 8'h78, 1, 0, 1, 0, 0, 1, 2'd3, 1, 99, 0);
    // R8: alignment checks
    run_op("R8", 8'h87, 8'h08, 0, 0, 0, 0, 0, 0, 2'd3, 1, 42, 0);
    run_op("R8", 8'h87, 8'h10, 1, 1, 0, 0, 0, 0, 2'd3, 1, 44, 0);
    run_op("R8", 8'h87, 8'h10, 1, 1, 0, 0, 0, 0, 2'd0, 1, 44, 1);
    run_op("R8", 8'h87, 8'h18, 0, 0, 0, 0, 0, 0, 2'd3, 0, 61, 0);
    run_op("R8", 8'h87, 8'h28, 0, 0, 0, 0, 1, 0, 2'd3, 1, 10, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule